// File: doc/BRIEF.md
# Byte-Coded Accumulator Sequencer

This block is a small 8-bit accumulator processor core. It runs through byte-coded instructions held in a byte-wide memory with a 16-bit address. It keeps a program counter and a decoded instruction register. It also keeps one accumulator and a five-bit condition-code register. Every memory access is a read that takes one clock cycle, and every read advances the program counter by one.

Two instructions are implemented, both with an immediate operand. The first loads the accumulator with the byte that follows the opcode. The second adds that byte to the accumulator. Each instruction takes exactly two read cycles: an opcode fetch, then an operand read. A one-cycle completion pulse follows each instruction, so the program counter, accumulator and flags can be checked at every instruction boundary.

The core decodes the opcode from its two nibbles. A high nibble of 8 selects immediate addressing on the accumulator. Within that, a low nibble of 6 is a load and a low nibble of B is an add. Any other opcode halts the core until reset.

Top module: `acc8_core`

## Requirements
- R1: While `rst` is high at a rising edge, the core loads `pc_o` from `rst_addr`, clears `done_o` and `illegal_o`, and enters the opcode-fetch state. The accumulator and flags are not reset.
- R2: In every fetch or operand cycle, `mem_rd` is 1 and `mem_addr` equals `pc_o`. `mem_rdata` must be valid in that same cycle. After each read cycle `pc_o` has grown by exactly one.
- R3: Each legal instruction uses exactly two read cycles, an opcode fetch and then an operand read. `done_o` is high for exactly one cycle, the cycle after the operand read. In that cycle `pc_o`, `acc_o` and `flags_o` already show the result.
- R4: Opcode 0x86 loads `acc_o` with the operand byte. It sets N from bit 7 of that byte, sets Z when the byte is zero, clears V, and leaves H and C unchanged.
- R5: Opcode 0x8B replaces `acc_o` with (accumulator + operand) modulo 256.
- R6: After an add, C (`flags_o[0]`) is the carry out of bit 7 and H (`flags_o[4]`) is the carry out of bit 3.
- R7: After an add, N (`flags_o[3]`) is bit 7 of the result, Z (`flags_o[2]`) is set when the result is zero, and V (`flags_o[1]`) flags a two's-complement overflow.
- R8: A fetched opcode other than 0x86 or 0x8B sets `illegal_o` in the next cycle. From then until reset, `mem_rd` and `done_o` stay at 0, and `pc_o` and `acc_o` hold their values.
- R9: Starting at 0xF800 with the bytes 86 24 8B 12 in memory, the first instruction ends with A = 0x24 and PC = 0xF802. The second ends with A = 0x36 and PC = 0xF804.
- R10: The program counter wraps from 0xFFFF to 0x0000, and an instruction that straddles the wrap runs normally.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge active |
| rst | input | 1 | Synchronous active-high reset |
| rst_addr | input | 16 | Address loaded into the program counter at reset |
| mem_addr | output | 16 | Read address (equals the program counter) |
| mem_rd | output | 1 | Read strobe, high in fetch and operand cycles |
| mem_rdata | input | 8 | Read data, valid in the cycle of the strobe |
| pc_o | output | 16 | Program counter |
| acc_o | output | 8 | Accumulator |
| flags_o | output | 5 | Condition codes {H, N, Z, V, C}, H in bit 4 |
| done_o | output | 1 | One-cycle pulse at the end of each instruction |
| illegal_o | output | 1 | Sticky flag for an unrecognised opcode; the core is halted |

## Verification
Several properties are checked on every cycle against the read history of the port. These are the address-equals-PC rule and the one-step PC advance. Others are the single-cycle completion pulse, the accumulator value after a load or add, and the frozen state after an illegal opcode. Flag values after an add, the exact two-cycle spacing between completions, the address wrap and the given four-byte test program can only be shown by the bench's scenarios. The bench compares each completion against an independently computed expected PC, accumulator and flag set.

// File: rtl/acc8_pkg.sv
package acc8_pkg;

    localparam int BYTE_W = 8;
    localparam int NIB_W  = BYTE_W / 2;
    localparam int CCR_W  = 5;

    // Opcode fields: high nibble selects mode/accumulator, low nibble the function
    localparam logic [NIB_W-1:0] MODE_IMM_A = 4'h8;
    localparam logic [NIB_W-1:0] FN_LOAD    = 4'h6;
    localparam logic [NIB_W-1:0] FN_ADD     = 4'hB;

    localparam logic [BYTE_W-1:0] OPC_LOAD = {MODE_IMM_A, FN_LOAD};
    localparam logic [BYTE_W-1:0] OPC_ADD  = {MODE_IMM_A, FN_ADD};

    typedef enum logic [1:0] {
        SQ_FETCH = 2'd0,
        SQ_OPND  = 2'd1,
        SQ_STOP  = 2'd2
    } seq_state_t;

    typedef enum logic [1:0] {
        OP_NONE = 2'd0,
        OP_LOAD = 2'd1,
        OP_ADD  = 2'd2
    } op_kind_t;

    typedef struct packed {
        logic half;
        logic neg;
        logic zero;
        logic ovf;
        logic carry;
    } ccr_t;

    function automatic op_kind_t classify(input logic [BYTE_W-1:0] opc);
        op_kind_t k;
        k = OP_NONE;
        if (opc[BYTE_W-1:NIB_W] == MODE_IMM_A) begin
            if (opc[NIB_W-1:0] == FN_LOAD)     k = OP_LOAD;
            else if (opc[NIB_W-1:0] == FN_ADD) k = OP_ADD;
        end
        return k;
    endfunction

endpackage

// File: rtl/acc8_decode.sv
module acc8_decode
    import acc8_pkg::*;
(
    input  logic [BYTE_W-1:0] opcode,
    output op_kind_t          kind,
    output logic              legal
);
    always_comb begin
        kind  = classify(opcode);
        legal = (kind != OP_NONE);
    end
endmodule

// File: rtl/acc8_alu.sv
module acc8_alu
    import acc8_pkg::*;
#(
    parameter int W = BYTE_W
) (
    input  logic [W-1:0] a,
    input  logic [W-1:0] b,
    input  op_kind_t     kind,
    input  ccr_t         ccr_in,
    output logic [W-1:0] result,
    output ccr_t         ccr_out
);
    localparam int HB = W / 2;

    logic [W:0] full;

    always_comb begin
        full    = {1'b0, a} + {1'b0, b};
        result  = a;
        ccr_out = ccr_in;
        unique case (kind)
            OP_LOAD: begin
                result       = b;
                ccr_out.neg  = b[W-1];
                ccr_out.zero = (b == '0);
                ccr_out.ovf  = 1'b0;
            end
            OP_ADD: begin
                result        = full[W-1:0];
                ccr_out.half  = a[HB] ^ b[HB] ^ full[HB];
                ccr_out.neg   = full[W-1];
                ccr_out.zero  = (full[W-1:0] == '0);
                ccr_out.ovf   = (a[W-1] == b[W-1]) && (full[W-1] != a[W-1]);
                ccr_out.carry = full[W];
            end
            default: ;
        endcase
    end
endmodule

// File: rtl/acc8_seq.sv
module acc8_seq
    import acc8_pkg::*;
#(
    parameter int ADDR_W = 16
) (
    input  logic              clk,
    input  logic              rst,
    input  logic [ADDR_W-1:0] rst_addr,
    input  logic [BYTE_W-1:0] rdata,
    output logic [ADDR_W-1:0] pc,
    output logic              rd,
    output logic              exec_en,
    output op_kind_t          exec_kind,
    output logic              done,
    output logic              halted
);
    seq_state_t        state_q;
    logic [ADDR_W-1:0] pc_q;
    op_kind_t          kind_q;
    logic              done_q;
    logic              ill_q;
    op_kind_t          fetch_kind;
    logic              fetch_legal;

    acc8_decode dec_i (
        .opcode (rdata),
        .kind   (fetch_kind),
        .legal  (fetch_legal)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            state_q <= SQ_FETCH;
            pc_q    <= rst_addr;
            kind_q  <= OP_NONE;
            done_q  <= 1'b0;
            ill_q   <= 1'b0;
        end else begin
            done_q <= 1'b0;
            unique case (state_q)
                SQ_FETCH: begin
                    pc_q   <= pc_q + ADDR_W'(1);
                    kind_q <= fetch_kind;
                    if (fetch_legal) begin
                        state_q <= SQ_OPND;
                    end else begin
                        state_q <= SQ_STOP;
                        ill_q   <= 1'b1;
                    end
                end
                SQ_OPND: begin
                    pc_q    <= pc_q + ADDR_W'(1);
                    done_q  <= 1'b1;
                    state_q <= SQ_FETCH;
                end
                default: state_q <= SQ_STOP;
            endcase
        end
    end

    assign pc        = pc_q;
    assign rd        = (state_q == SQ_FETCH) || (state_q == SQ_OPND);
    assign exec_en   = (state_q == SQ_OPND);
    assign exec_kind = kind_q;
    assign done      = done_q;
    assign halted    = ill_q;
endmodule

// File: rtl/acc8_core.sv
module acc8_core
    import acc8_pkg::*;
#(
    parameter int ADDR_W = 16
) (
    input  logic                 clk,
    input  logic                 rst,
    input  logic [ADDR_W-1:0]    rst_addr,
    output logic [ADDR_W-1:0]    mem_addr,
    output logic                 mem_rd,
    input  logic [BYTE_W-1:0]    mem_rdata,
    output logic [ADDR_W-1:0]    pc_o,
    output logic [BYTE_W-1:0]    acc_o,
    output logic [CCR_W-1:0]     flags_o,
    output logic                 done_o,
    output logic                 illegal_o
);
    logic [ADDR_W-1:0] pc_w;
    logic              exec_en;
    op_kind_t          exec_kind;
    logic [BYTE_W-1:0] acc_q;
    logic [BYTE_W-1:0] alu_res;
    ccr_t              ccr_q;
    ccr_t              alu_ccr;

    acc8_seq #(.ADDR_W(ADDR_W)) seq_i (
        .clk       (clk),
        .rst       (rst),
        .rst_addr  (rst_addr),
        .rdata     (mem_rdata),
        .pc        (pc_w),
        .rd        (mem_rd),
        .exec_en   (exec_en),
        .exec_kind (exec_kind),
        .done      (done_o),
        .halted    (illegal_o)
    );

    acc8_alu #(.W(BYTE_W)) alu_i (
        .a       (acc_q),
        .b       (mem_rdata),
        .kind    (exec_kind),
        .ccr_in  (ccr_q),
        .result  (alu_res),
        .ccr_out (alu_ccr)
    );

    // Accumulator and flags carry no reset; they change only in operand cycles
    always_ff @(posedge clk) begin
        if (!rst && exec_en) begin
            acc_q <= alu_res;
            ccr_q <= alu_ccr;
        end
    end

    assign mem_addr = pc_w;
    assign pc_o     = pc_w;
    assign acc_o    = acc_q;
    assign flags_o  = ccr_q;
endmodule

// File: rtl/acc8_core_chk.sv
module acc8_core_chk
    import acc8_pkg::*;
#(
    parameter int ADDR_W = 16
) (
    input logic                 clk,
    input logic                 rst,
    input logic [ADDR_W-1:0]    rst_addr,
    input logic [ADDR_W-1:0]    mem_addr,
    input logic                 mem_rd,
    input logic [BYTE_W-1:0]    mem_rdata,
    input logic [ADDR_W-1:0]    pc_o,
    input logic [BYTE_W-1:0]    acc_o,
    input logic [CCR_W-1:0]     flags_o,
    input logic                 done_o,
    input logic                 illegal_o
);
    // R1
    rst_load_chk: assert property (@(posedge clk)
        rst |=> (pc_o == $past(rst_addr) && !done_o && !illegal_o));

    // R2
    rd_addr_chk: assert property (@(posedge clk) disable iff (rst)
        mem_rd |-> (mem_addr == pc_o));

    // R2
    pc_step_chk: assert property (@(posedge clk) disable iff (rst)
        (!rst && mem_rd) |=> (pc_o == ADDR_W'($past(pc_o) + 1'b1)));

    // R3
    done_pulse_chk: assert property (@(posedge clk) disable iff (rst)
        done_o |=> !done_o);

    // R3
    done_after_read_chk: assert property (@(posedge clk) disable iff (rst)
        done_o |-> ($past(mem_rd) && !illegal_o));

    // R4
    load_val_chk: assert property (@(posedge clk) disable iff (rst)
        (done_o && $past(mem_rdata, 2) == OPC_LOAD) |->
        (acc_o == $past(mem_rdata) && !flags_o[1]
         && flags_o[4] == $past(flags_o[4]) && flags_o[0] == $past(flags_o[0])));

    // R5
    add_val_chk: assert property (@(posedge clk) disable iff (rst)
        (done_o && $past(mem_rdata, 2) == OPC_ADD) |->
        (acc_o == BYTE_W'($past(acc_o) + $past(mem_rdata))));

    // R8
    halt_hold_chk: assert property (@(posedge clk) disable iff (rst)
        (!rst && illegal_o) |=> (illegal_o && $stable(pc_o) && $stable(acc_o)));

    // R8
    halt_quiet_chk: assert property (@(posedge clk) disable iff (rst)
        illegal_o |-> (!mem_rd && !done_o));
endmodule

bind acc8_core acc8_core_chk #(.ADDR_W(ADDR_W)) chk_i (
    .clk       (clk),
    .rst       (rst),
    .rst_addr  (rst_addr),
    .mem_addr  (mem_addr),
    .mem_rd    (mem_rd),
    .mem_rdata (mem_rdata),
    .pc_o      (pc_o),
    .acc_o     (acc_o),
    .flags_o   (flags_o),
    .done_o    (done_o),
    .illegal_o (illegal_o)
);

// File: tb/acc8_core_tb_top.sv
module acc8_core_tb_top;
    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic [15:0] rst_addr = 16'hF800;
    logic [15:0] mem_addr;
    logic        mem_rd;
    logic [7:0]  mem_rdata;
    logic [15:0] pc_o;
    logic [7:0]  acc_o;
    logic [4:0]  flags_o;
    logic        done_o;
    logic        illegal_o;

    logic [7:0] mem [0:255];
    assign mem_rdata = mem[mem_addr[7:0]];

    always #2 clk = ~clk;

    acc8_core #(.ADDR_W(16)) dut_i (
        .clk       (clk),
        .rst       (rst),
        .rst_addr  (rst_addr),
        .mem_addr  (mem_addr),
        .mem_rd    (mem_rd),
        .mem_rdata (mem_rdata),
        .pc_o      (pc_o),
        .acc_o     (acc_o),
        .flags_o   (flags_o),
        .done_o    (done_o),
        .illegal_o (illegal_o)
    );

    int checks = 0;
    int fails  = 0;
    int cyc    = 0;
    bit finished = 0;

    // Scoreboard queues: expected state at each completion
    logic [15:0] exp_pc_q [$];
    logic [7:0]  exp_acc_q [$];
    logic [4:0]  exp_fl_q [$];
    logic [4:0]  exp_msk_q [$];
    string       exp_tag_q [$];

    task automatic check(input bit ok, input string tag, input string what,
                         input logic [15:0] got, input logic [15:0] exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s %s: actual %h expected %h", tag, what, got, exp);
        end
    endtask

    task automatic clear_mem();
        for (int i = 0; i < 256; i++) mem[i] = 8'h00;
    endtask

    task automatic put(input logic [15:0] a, input logic [7:0] d);
        mem[a[7:0]] = d;
    endtask

    task automatic expect_done(input logic [15:0] pc, input logic [7:0] acc,
                               input logic [4:0] fl, input logic [4:0] msk,
                               input string tag);
        exp_pc_q.push_back(pc);
        exp_acc_q.push_back(acc);
        exp_fl_q.push_back(fl);
        exp_msk_q.push_back(msk);
        exp_tag_q.push_back(tag);
    endtask

    task automatic run_from(input logic [15:0] start);
        @(negedge clk);
        rst = 1'b1;
        rst_addr = start;
        repeat (2) @(negedge clk);
        rst = 1'b0;
        for (int n = 0; n < 200 && exp_pc_q.size() != 0; n++) @(negedge clk);
        check(exp_pc_q.size() == 0, "R3", "pending completions", 16'(exp_pc_q.size()), 16'd0);
    endtask

    // Monitor: samples just after each rising edge, inputs change on falling edges
    int          gap = 0;
    logic        prev_rd = 1'b0;
    logic [15:0] prev_pc = '0;

    always @(posedge clk) begin
        cyc++;
        #1;
        if (rst) begin
            gap = 0;
            // R1 reset state
            check(pc_o == rst_addr, "R1", "pc at reset", pc_o, rst_addr);
            check(!done_o && !illegal_o, "R1", "done/illegal at reset",
                  {14'd0, done_o, illegal_o}, 16'd0);
        end else begin
            gap++;
            if (prev_rd)
                check(pc_o == prev_pc + 16'd1, "R2", "pc step", pc_o, prev_pc + 16'd1);
            if (!illegal_o)
                check(mem_rd && mem_addr == pc_o, "R2", "read strobe/address", mem_addr, pc_o);
            if (done_o) begin
                check(gap == 2, "R3", "cycles per instruction", 16'(gap), 16'd2);
                gap = 0;
                if (exp_pc_q.size() == 0) begin
                    check(1'b0, "R3", "unexpected completion", pc_o, 16'hxxxx);
                end else begin
                    logic [15:0] epc;
                    logic [7:0]  eacc;
                    logic [4:0]  efl;
                    logic [4:0]  emsk;
                    string       etag;
                    epc  = exp_pc_q.pop_front();
                    eacc = exp_acc_q.pop_front();
                    efl  = exp_fl_q.pop_front();
                    emsk = exp_msk_q.pop_front();
                    etag = exp_tag_q.pop_front();
                    check(pc_o == epc, etag, "pc", pc_o, epc);
                    check(acc_o == eacc, etag, "acc", {8'd0, acc_o}, {8'd0, eacc});
                    check(((flags_o ^ efl) & emsk) == 5'd0, etag, "flags HNZVC",
                          {11'd0, flags_o & emsk}, {11'd0, efl & emsk});
                end
            end
        end
        prev_rd = mem_rd && !rst;
        prev_pc = pc_o;
    end

    task automatic finish_run();
        if (!finished) begin
            finished = 1;
            $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
            $finish;
        end
    endtask

    initial begin
        wait (cyc > 20000);
        fails++;
        $display("FAIL watchdog: actual cycle %0d expected below 20000", cyc);
        finish_run();
    end

    initial begin
        clear_mem();
        repeat (3) @(negedge clk);

        // R9 given program; first load leaves H and C undefined
        clear_mem();
        put(16'hF800, 8'h86); put(16'hF801, 8'h24);
        put(16'hF802, 8'h8B); put(16'hF803, 8'h12);
        expect_done(16'hF802, 8'h24, 5'b00000, 5'b01110, "R9");
        expect_done(16'hF804, 8'h36, 5'b00000, 5'b11111, "R9");
        run_from(16'hF800);

        // R4 R5 R6 R7 flag corners
        clear_mem();
        put(16'h0010, 8'h86); put(16'h0011, 8'h7F);
        put(16'h0012, 8'h8B); put(16'h0013, 8'h01);
        put(16'h0014, 8'h8B); put(16'h0015, 8'h80);
        put(16'h0016, 8'h86); put(16'h0017, 8'h00);
        put(16'h0018, 8'h8B); put(16'h0019, 8'h0F);
        put(16'h001A, 8'h8B); put(16'h001B, 8'hFF);
        expect_done(16'h0012, 8'h7F, 5'b00000, 5'b01110, "R4");
        expect_done(16'h0014, 8'h80, 5'b11010, 5'b11111, "R7");
        expect_done(16'h0016, 8'h00, 5'b00111, 5'b11111, "R6");
        expect_done(16'h0018, 8'h00, 5'b00101, 5'b11111, "R4");
        expect_done(16'h001A, 8'h0F, 5'b00000, 5'b11111, "R5");
        expect_done(16'h001C, 8'h0E, 5'b10001, 5'b11111, "R6");
        run_from(16'h0010);

        // R10 address wrap
        clear_mem();
        put(16'hFFFE, 8'h86); put(16'hFFFF, 8'h55);
        put(16'h0000, 8'h8B); put(16'h0001, 8'h01);
        expect_done(16'h0000, 8'h55, 5'b00000, 5'b01110, "R10");
        expect_done(16'h0002, 8'h56, 5'b00000, 5'b11111, "R10");
        run_from(16'hFFFE);

        // R8 illegal opcode 0x12 after a load
        clear_mem();
        put(16'h0040, 8'h86); put(16'h0041, 8'h33); put(16'h0042, 8'h12);
        expect_done(16'h0042, 8'h33, 5'b00000, 5'b01110, "R8");
        @(negedge clk);
        rst = 1'b1;
        rst_addr = 16'h0040;
        repeat (2) @(negedge clk);
        rst = 1'b0;
        for (int n = 0; n < 50 && exp_pc_q.size() != 0; n++) @(negedge clk);
        @(negedge clk);
        for (int k = 0; k < 4; k++) begin
            check(illegal_o == 1'b1, "R8", "illegal flag", {15'd0, illegal_o}, 16'd1);
            check(!mem_rd && !done_o, "R8", "strobe/done halted", {14'd0, mem_rd, done_o}, 16'd0);
            check(pc_o == 16'h0043, "R8", "pc frozen", pc_o, 16'h0043);
            check(acc_o == 8'h33, "R8", "acc frozen", {8'd0, acc_o}, 16'h0033);
            @(negedge clk);
        end

        // R1 reset clears the halt
        rst = 1'b1;
        rst_addr = 16'h0040;
        @(negedge clk);
        check(!illegal_o && pc_o == 16'h0040, "R1", "halt cleared by reset", pc_o, 16'h0040);
        @(negedge clk);
        finish_run();
    end
endmodule